// File: doc/BRIEF.md
# In-Order Transaction Scoreboard with Register Model

This block is a synthesizable checker that sits beside a peripheral bus. It takes two transaction streams: one carries the transactions a stimulus source intends to issue, the other carries the transactions a bus monitor actually saw. Each transaction has a direction (write or read), a 32-bit address and 32-bit data. Intended transactions are queued in arrival order. Each observed transaction is compared with the oldest queued entry, and the result is reported as a one-cycle pulse and in saturating pass and fail counters.

The stimulus source never supplies read data. The block keeps its own 16-word register model. Every accepted intended write updates that model. Every accepted intended read takes its expected data from the model at the moment it is accepted, so it reflects all earlier intended writes.

The result logic is a small state machine with four states. RES_IDLE means no observed transaction arrived in the previous cycle. RES_MATCH, RES_MISMATCH and RES_UNEXP each last one cycle and drive the matching pulse. On every clock edge the machine moves to RES_UNEXP if an observed transaction arrives while the queue is empty. It moves to RES_MATCH if the transaction equals the queue head, and to RES_MISMATCH if it differs. With no observed transaction, it returns to RES_IDLE.

Top module: `txn_scoreboard`

## Requirements
- R1: After reset the register model holds zero in every word, both counters read 0, all result pulses are low and `exp_ready` is high.
- R2: An accepted intended write stores its data in model word `addr[5:2]`. Any later intended read that maps to the same word, including one at an aliased address such as 0x08 after a write to 0x48, expects that data.
- R3: An accepted intended read takes its expected data from the model. A word that has never been written gives 0.
- R4: Observed transactions are compared with intended transactions strictly in the order in which the intended ones were accepted. Each comparison consumes the oldest entry.
- R5: The queue holds 8 entries. With 8 pending, `exp_ready` is low. An intended transaction offered while `exp_ready` is low is neither queued nor applied to the model.
- R6: An observed transaction that arrives with the queue empty raises `unexp_pulse` in the next cycle. It leaves both counters unchanged and consumes nothing.
- R7: An observed transaction whose direction, address and data all equal the queue head raises `match_pulse` in the cycle after it is presented, and `pass_count` increases by one.
- R8: A difference in direction, address or data raises `mismatch_pulse` in the cycle after presentation, and `fail_count` increases by one.
- R9: Both counters are 16 bits wide and hold at 65535 once they reach it.
- R10: Each result pulse lasts exactly one cycle per observed transaction, and at most one of the three pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exp_valid | input | 1 | Intended transaction offered |
| exp_ready | output | 1 | Queue can take an intended transaction |
| exp_write | input | 1 | Intended direction, 1 = write |
| exp_addr | input | 32 | Intended address |
| exp_wdata | input | 32 | Intended write data (ignored for reads) |
| obs_valid | input | 1 | Observed transaction present |
| obs_write | input | 1 | Observed direction, 1 = write |
| obs_addr | input | 32 | Observed address |
| obs_data | input | 32 | Observed write data or returned read data |
| match_pulse | output | 1 | Last observed transaction matched |
| mismatch_pulse | output | 1 | Last observed transaction differed |
| unexp_pulse | output | 1 | Last observed transaction had no pending entry |
| pass_count | output | 16 | Saturating match count |
| fail_count | output | 16 | Saturating mismatch count |

## Verification
The comparison is tried with matching write-then-read pairs, reads of never-written words, and aliased addresses. These separate a model that is indexed by word address from one that uses the full address or never updates. Three transactions each differing in exactly one field show that direction, address and data are all compared. Observed transactions presented in swapped order show that the head is used rather than a search. Filling the queue, offering one refused write and then draining shows that refusal touches neither the queue nor the model. A long matched stream drives the pass counter into saturation.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int SB_AW = 32;
    localparam int SB_DW = 32;

    typedef struct packed {
        logic             write;
        logic [SB_AW-1:0] addr;
        logic [SB_DW-1:0] data;
    } sb_txn_t;

    typedef enum logic [1:0] {
        RES_IDLE,
        RES_MATCH,
        RES_MISMATCH,
        RES_UNEXP
    } res_state_t;
endpackage

// File: rtl/sb_regmodel.sv
module sb_regmodel #(
    parameter int WORDS = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

    // R2: a write lands in the addressed word
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/sb_fifo.sv
module sb_fifo
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  sb_txn_t push_txn,
    input  logic    pop,
    output sb_txn_t head,
    output logic    full,
    output logic    empty
);
    sb_txn_t         slots [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_txn;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // R5: the parent never pushes into a full queue
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R6: nothing is consumed from an empty queue
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/sb_sat_counter.sv
module sb_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n)                   value <= '0;
        else if (inc && value != '1)  value <= value + W'(1);
    end

    // R9: once at the top the counter stays there
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (value == '1) |=> (value == '1));
endmodule

// File: rtl/txn_scoreboard.sv
module txn_scoreboard
    import sb_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int REG_WORDS = 16,
    parameter int CNT_W     = 16,
    localparam int IW       = $clog2(REG_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exp_valid,
    output logic             exp_ready,
    input  logic             exp_write,
    input  logic [SB_AW-1:0] exp_addr,
    input  logic [SB_DW-1:0] exp_wdata,
    input  logic             obs_valid,
    input  logic             obs_write,
    input  logic [SB_AW-1:0] obs_addr,
    input  logic [SB_DW-1:0] obs_data,
    output logic             match_pulse,
    output logic             mismatch_pulse,
    output logic             unexp_pulse,
    output logic [CNT_W-1:0] pass_count,
    output logic [CNT_W-1:0] fail_count
);
    sb_txn_t    head, push_txn, obs_txn;
    logic       q_full, q_empty, push, pop;
    logic [SB_DW-1:0] model_rd;
    res_state_t state, next_state;

    assign exp_ready = !q_full;
    assign push      = exp_valid && exp_ready;
    assign pop       = obs_valid && !q_empty;

    sb_regmodel #(.WORDS(REG_WORDS), .DW(SB_DW)) u_model (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push && exp_write),
        .wr_idx  (exp_addr[IW+1:2]),
        .wr_data (exp_wdata),
        .rd_idx  (exp_addr[IW+1:2]),
        .rd_data (model_rd)
    );

    always_comb begin
        push_txn.write = exp_write;
        push_txn.addr  = exp_addr;
        push_txn.data  = exp_write ? exp_wdata : model_rd;
        obs_txn.write  = obs_write;
        obs_txn.addr   = obs_addr;
        obs_txn.data   = obs_data;
    end

    sb_fifo #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_txn (push_txn),
        .pop      (pop),
        .head     (head),
        .full     (q_full),
        .empty    (q_empty)
    );

    // next-state decision
    always_comb begin
        if (!obs_valid)          next_state = RES_IDLE;
        else if (q_empty)        next_state = RES_UNEXP;
        else if (head == obs_txn) next_state = RES_MATCH;
        else                     next_state = RES_MISMATCH;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RES_IDLE;
        else        state <= next_state;
    end

    // outputs
    always_comb begin
        match_pulse    = 1'b0;
        mismatch_pulse = 1'b0;
        unexp_pulse    = 1'b0;
        unique case (state)
            RES_IDLE:     ;
            RES_MATCH:    match_pulse    = 1'b1;
            RES_MISMATCH: mismatch_pulse = 1'b1;
            RES_UNEXP:    unexp_pulse    = 1'b1;
        endcase
    end

    sb_sat_counter #(.W(CNT_W)) u_pass (
        .clk (clk), .rst_n (rst_n),
        .inc (next_state == RES_MATCH), .value (pass_count));

    sb_sat_counter #(.W(CNT_W)) u_fail (
        .clk (clk), .rst_n (rst_n),
        .inc (next_state == RES_MISMATCH), .value (fail_count));

    // R10: at most one result pulse at a time
    a_r10_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({match_pulse, mismatch_pulse, unexp_pulse}));
    // R6: stray observation flags an error and leaves counters alone
    a_r6_stray: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_valid && q_empty) |=> unexp_pulse && $stable(pass_count) && $stable(fail_count));
    // R7: a match advances the pass counter unless saturated
    a_r7_pass_step: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (pass_count == CNT_W'($past(pass_count) + 1'b1)) || ($past(pass_count) == '1));
    // R8: a mismatch advances the fail counter unless saturated
    a_r8_fail_step: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_pulse |-> (fail_count == CNT_W'($past(fail_count) + 1'b1)) || ($past(fail_count) == '1));
    // R5: refusal keeps ready low until something is consumed
    a_r5_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!exp_ready && !obs_valid) |=> !exp_ready);
endmodule

// File: tb/txn_scoreboard_test.sv
module txn_scoreboard_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        exp_valid, exp_write, obs_valid, obs_write;
    logic        exp_ready, match_pulse, mismatch_pulse, unexp_pulse;
    logic [31:0] exp_addr, exp_wdata, obs_addr, obs_data;
    logic [15:0] pass_count, fail_count;

    int checks = 0;
    int failures = 0;
    int pass_m = 0;
    int fail_m = 0;

    always #10 clk = ~clk;  // 50 MHz

    txn_scoreboard uut (
        .clk(clk), .rst_n(rst_n),
        .exp_valid(exp_valid), .exp_ready(exp_ready), .exp_write(exp_write),
        .exp_addr(exp_addr), .exp_wdata(exp_wdata),
        .obs_valid(obs_valid), .obs_write(obs_write), .obs_addr(obs_addr),
        .obs_data(obs_data),
        .match_pulse(match_pulse), .mismatch_pulse(mismatch_pulse),
        .unexp_pulse(unexp_pulse), .pass_count(pass_count), .fail_count(fail_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push_exp(input logic w, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        exp_valid = 1'b1; exp_write = w; exp_addr = a; exp_wdata = d;
        @(negedge clk);
        exp_valid = 1'b0;
    endtask

    // kind: 0 match, 1 mismatch, 2 unexpected
    task automatic obs_chk(input logic w, input logic [31:0] a, input logic [31:0] d,
                           input int kind, input string req);
        @(negedge clk);
        obs_valid = 1'b1; obs_write = w; obs_addr = a; obs_data = d;
        @(negedge clk);
        obs_valid = 1'b0;
        if (kind == 0 && pass_m < 65535) pass_m++;
        if (kind == 1 && fail_m < 65535) fail_m++;
        chk({match_pulse, mismatch_pulse, unexp_pulse} ==
            ((kind == 0) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001),
            req, {match_pulse, mismatch_pulse, unexp_pulse},
            (kind == 0) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001);
        chk(pass_count == 16'(pass_m), {req, " pass_count"}, pass_count, pass_m);
        chk(fail_count == 16'(fail_m), {req, " fail_count"}, fail_count, fail_m);
        @(negedge clk);
        chk({match_pulse, mismatch_pulse, unexp_pulse} == 3'b000, "R10 pulse width",
            {match_pulse, mismatch_pulse, unexp_pulse}, 0);
    endtask

    task automatic t_reset;
        chk(exp_ready == 1'b1, "R1 ready", exp_ready, 1);
        chk(pass_count == 0 && fail_count == 0, "R1 counters", {pass_count, fail_count}, 0);
        chk({match_pulse, mismatch_pulse, unexp_pulse} == 0, "R1 pulses",
            {match_pulse, mismatch_pulse, unexp_pulse}, 0);
    endtask

    task automatic t_write_read;
        push_exp(1'b1, 32'h8, 32'hA5A5_0001);
        obs_chk(1'b1, 32'h8, 32'hA5A5_0001, 0, "R7 write match");
        push_exp(1'b0, 32'h8, 32'h0);
        obs_chk(1'b0, 32'h8, 32'hA5A5_0001, 0, "R2 read after write");
    endtask

    task automatic t_unwritten;
        push_exp(1'b0, 32'h20, 32'hFFFF_FFFF);
        obs_chk(1'b0, 32'h20, 32'h0, 0, "R1 R3 unwritten word reads zero");
    endtask

    task automatic t_alias;
        push_exp(1'b1, 32'h48, 32'd777);
        push_exp(1'b0, 32'h08, 32'h0);
        obs_chk(1'b1, 32'h48, 32'd777, 0, "R2 aliased write");
        obs_chk(1'b0, 32'h08, 32'd777, 0, "R2 aliased read");
    endtask

    task automatic t_fields;
        push_exp(1'b1, 32'hC, 32'd5);
        obs_chk(1'b0, 32'hC, 32'd5, 1, "R8 direction differs");
        push_exp(1'b1, 32'hC, 32'd5);
        obs_chk(1'b1, 32'h10, 32'd5, 1, "R8 address differs");
        push_exp(1'b0, 32'hC, 32'h0);
        obs_chk(1'b0, 32'hC, 32'd6, 1, "R8 data differs");
    endtask

    task automatic t_order;
        push_exp(1'b1, 32'h0, 32'd11);
        push_exp(1'b1, 32'h4, 32'd22);
        push_exp(1'b1, 32'h14, 32'd33);
        obs_chk(1'b1, 32'h0, 32'd11, 0, "R4 first in order");
        obs_chk(1'b1, 32'h14, 32'd33, 1, "R4 swapped vs head");
        obs_chk(1'b1, 32'h4, 32'd22, 1, "R4 head was consumed");
    endtask

    task automatic t_full;
        for (int i = 0; i < 8; i++) push_exp(1'b1, 32'(i * 4), 32'(100 + i));
        @(negedge clk);
        chk(exp_ready == 1'b0, "R5 ready low at 8 pending", exp_ready, 0);
        push_exp(1'b1, 32'h3C, 32'd999);
        for (int i = 0; i < 8; i++) obs_chk(1'b1, 32'(i * 4), 32'(100 + i), 0, "R5 drain");
        chk(exp_ready == 1'b1, "R5 ready back", exp_ready, 1);
        obs_chk(1'b1, 32'h3C, 32'd999, 2, "R5 R6 refused entry not queued");
        push_exp(1'b0, 32'h3C, 32'h0);
        obs_chk(1'b0, 32'h3C, 32'h0, 0, "R5 refused write left model");
    endtask

    task automatic t_stray;
        obs_chk(1'b1, 32'h4, 32'd1, 2, "R6 empty queue");
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 65540; i++) begin
            @(negedge clk);
            exp_valid = 1'b1; exp_write = 1'b1; exp_addr = 32'h0; exp_wdata = 32'(i);
            obs_valid = (i > 0); obs_write = 1'b1; obs_addr = 32'h0; obs_data = 32'(i - 1);
        end
        @(negedge clk);
        exp_valid = 1'b0;
        obs_valid = 1'b1; obs_data = 32'(65539);
        @(negedge clk);
        obs_valid = 1'b0;
        chk(pass_count == 16'hFFFF, "R9 pass saturates", pass_count, 16'hFFFF);
        chk(fail_count == 16'(fail_m), "R9 fail unchanged", fail_count, fail_m);
        pass_m = 65535;
        push_exp(1'b1, 32'h0, 32'd1);
        obs_chk(1'b1, 32'h0, 32'd1, 0, "R9 hold at max");
    endtask

    initial begin
        rst_n = 1'b0;
        exp_valid = 1'b0; exp_write = 1'b0; exp_addr = '0; exp_wdata = '0;
        obs_valid = 1'b0; obs_write = 1'b0; obs_addr = '0; obs_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_write_read;
        t_unwritten;
        t_alias;
        t_fields;
        t_order;
        t_stray;
        t_full;
        t_saturate;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule